// File: doc/BRIEF.md
# UART Transmit Queue and Status Flags

This block sits between a CPU write port and the transmit shift register of a UART channel. It holds up to eight characters in a queue. It sends a one-cycle load strobe with the oldest character whenever the shift register is idle. It keeps two status flags: `tx_ready` means the queue can take another character, and `tx_empty` means the transmitter has underrun, so both the queue and the shift register are idle. The serialiser sends back a one-cycle `sh_done` pulse once the last stop bit of a character is out.

Software drives the block with character writes and three commands: enable, disable and reset. A disable that arrives while a character is on the line is held until that character completes. A disable that arrives during underrun takes effect at once. A reset command empties the queue, drops any held disable and leaves the transmitter off. When several commands arrive in the same cycle, reset wins over disable, and disable wins over enable.

Top module: `uart_txq`

## Requirements
- R1: After `rst_n` is released, `tx_enabled`, `tx_ready`, `tx_empty` and `sh_load` are all 0.
- R2: An enable command given while disabled sets `tx_enabled` on the next cycle. It sets `tx_ready` if the queue holds fewer than 8 characters, and it sets `tx_empty` exactly when the queue is empty. An enable given while already enabled has no effect.
- R3: A write (`wr_valid` high) is stored only when `tx_ready` is 1 in that cycle. Otherwise the character is discarded and is never presented on `sh_data`.
- R4: The queue holds 8 characters. A stored write that occupies the last free entry, with no load in the same cycle, drives `tx_ready` to 0 on the next cycle. While enabled, `tx_ready` is 1 whenever fewer than 8 characters are queued.
- R5: `sh_load` is high for exactly one cycle when the transmitter is enabled, the shift register is idle (no load since the last `sh_done`) and the queue is not empty. `sh_data` then carries the oldest queued character, and `tx_ready` is 1 on the next cycle.
- R6: `tx_empty` becomes 1 on the cycle after `sh_done` when no disable is held and the queue is empty after that cycle. It becomes 0 on the cycle after any stored write.
- R7: A disable given while a character is being sent (or in the cycle it is loaded) leaves `tx_enabled` at 1 until `sh_done`. On the next cycle `tx_enabled`, `tx_ready` and `tx_empty` are all 0, and no further load is issued.
- R8: A disable given while enabled, with the shift register idle and the queue empty, clears `tx_enabled`, `tx_ready` and `tx_empty` on the next cycle.
- R9: A reset command clears `tx_enabled`, `tx_ready`, `tx_empty` and any held disable on the next cycle, suppresses `sh_load` in its own cycle and empties the queue. A later enable therefore reports `tx_empty` = 1.
- R10: Commands in the same cycle resolve as reset over disable over enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | CPU writes a character this cycle |
| wr_data | input | 8 | Character written by the CPU |
| cmd_enable | input | 1 | Enable-transmitter command pulse |
| cmd_disable | input | 1 | Disable-transmitter command pulse |
| cmd_reset | input | 1 | Transmitter reset command pulse |
| sh_done | input | 1 | Shift register finished the last stop bit |
| sh_load | output | 1 | One-cycle strobe: shift register takes `sh_data` |
| sh_data | output | 8 | Oldest queued character |
| tx_ready | output | 1 | Queue can accept another character |
| tx_empty | output | 1 | Transmitter underrun |
| tx_enabled | output | 1 | Transmitter currently enabled |

## Verification
A wrong queue count shows up at the ports within one cycle. A stale count leaves `tx_ready` high with 8 characters queued, or low with one entry free, and a queue that sends out a dropped character changes `sh_data` at the next load. A lost busy or held-disable bit shows within one cycle as well: a second `sh_load` appears while a character is still on the line, or `tx_enabled` stays high after the `sh_done` that should have turned it off. A wrong underrun bit shows as `tx_empty` out of step on the cycle after `sh_done`. Comparing every output against a behavioural model on every clock therefore catches each of these faults in the cycle it first becomes visible.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_ENABLE  = 2'd1,
    CMD_DISABLE = 2'd2,
    CMD_RESET   = 2'd3
  } txq_cmd_e;

  // Resolve simultaneous commands: reset over disable over enable.
  function automatic txq_cmd_e pick_cmd(logic en, logic dis, logic rst);
    if (rst)      return CMD_RESET;
    else if (dis) return CMD_DISABLE;
    else if (en)  return CMD_ENABLE;
    else          return CMD_NONE;
  endfunction

  // Circular index advance for any depth.
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle.
  function automatic int unsigned level_step(int unsigned lvl, logic push,
                                             logic pop, logic flush);
    int unsigned r;
    if (flush) return 0;
    r = lvl;
    if (push) r = r + 1;
    if (pop)  r = r - 1;
    return r;
  endfunction

endpackage

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic [LW-1:0]    level,
  output logic [LW-1:0]    level_nx
);
  import uart_txq_pkg::*;

  logic [AW-1:0]    wr_q, rd_q;
  logic [WIDTH-1:0] slot_w [DEPTH];
  logic             do_push, do_pop;

  assign do_push = push && !flush;
  assign do_pop  = pop && !flush;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk) begin
      if (do_push && wr_q == AW'(i)) q <= push_data;
    end
    assign slot_w[i] = q;
  end

  assign head_data = slot_w[rd_q];
  assign level_nx  = LW'(level_step(int'(level), do_push, do_pop, flush));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      level <= '0;
    end else begin
      level <= level_nx;
      if (flush) begin
        wr_q <= '0;
        rd_q <= '0;
      end else begin
        if (do_push) wr_q <= AW'(wrap_inc(int'(wr_q), DEPTH));
        if (do_pop)  rd_q <= AW'(wrap_inc(int'(rd_q), DEPTH));
      end
    end
  end

endmodule

// File: rtl/uart_txq_ctrl.sv
module uart_txq_ctrl
  import uart_txq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  txq_cmd_e cmd,
  input  logic     sh_done,
  input  logic     q_empty,
  output logic     enabled,
  output logic     busy,
  output logic     pend_dis,
  output logic     load_fire,
  output logic     start_ev,
  output logic     stop_ev,
  output logic     done_idle
);
  logic is_rst, is_dis, is_en;
  logic finishing, dis_defer, dis_now, done_exec;

  assign is_rst = (cmd == CMD_RESET);
  assign is_dis = (cmd == CMD_DISABLE);
  assign is_en  = (cmd == CMD_ENABLE);

  assign load_fire = enabled && !busy && !q_empty && !is_rst;
  assign finishing = busy && sh_done;

  // A disable waits while a character is on the line or being loaded now.
  assign dis_defer = is_dis && enabled && ((busy && !sh_done) || load_fire);
  assign dis_now   = is_dis && enabled && !dis_defer;
  assign done_exec = finishing && pend_dis && !is_rst && !dis_now;

  assign start_ev  = is_en && !enabled;
  assign stop_ev   = dis_now || done_exec;
  assign done_idle = finishing && !pend_dis && !is_rst && !dis_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled  <= 1'b0;
      busy     <= 1'b0;
      pend_dis <= 1'b0;
    end else if (is_rst) begin
      enabled  <= 1'b0;
      busy     <= 1'b0;
      pend_dis <= 1'b0;
    end else begin
      if (load_fire)      busy <= 1'b1;
      else if (sh_done)   busy <= 1'b0;

      if (stop_ev)        enabled <= 1'b0;
      else if (start_ev)  enabled <= 1'b1;

      if (stop_ev)        pend_dis <= 1'b0;
      else if (dis_defer) pend_dis <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_txq_flags.sv
module uart_txq_flags #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          enabled,
  input  logic          push,
  input  logic          done_idle,
  input  logic [LW-1:0] level_nx,
  output logic          tx_ready,
  output logic          tx_empty
);
  logic has_room, none_left;

  assign has_room  = level_nx < LW'(DEPTH);
  assign none_left = level_nx == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ready <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      if (flush || stop_ev)          tx_ready <= 1'b0;
      else if (start_ev || enabled)  tx_ready <= has_room;
      else                           tx_ready <= 1'b0;

      if (flush || stop_ev || push)  tx_empty <= 1'b0;
      else if (start_ev)             tx_empty <= none_left;
      else if (done_idle && none_left) tx_empty <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             cmd_enable,
  input  logic             cmd_disable,
  input  logic             cmd_reset,
  input  logic             sh_done,
  output logic             sh_load,
  output logic [WIDTH-1:0] sh_data,
  output logic             tx_ready,
  output logic             tx_empty,
  output logic             tx_enabled
);
  import uart_txq_pkg::*;

  localparam int LW = $clog2(DEPTH + 1);

  txq_cmd_e      cmd;
  logic          flush, wr_accept, load_fire, busy, pend_dis;
  logic          start_ev, stop_ev, done_idle;
  logic [LW-1:0] fifo_level, fifo_level_nx;

  assign cmd       = pick_cmd(cmd_enable, cmd_disable, cmd_reset);
  assign flush     = (cmd == CMD_RESET);
  assign wr_accept = wr_valid && tx_ready && !flush;
  assign sh_load   = load_fire;

  uart_txq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(wr_accept),
    .push_data(wr_data), .pop(load_fire), .head_data(sh_data),
    .level(fifo_level), .level_nx(fifo_level_nx)
  );

  uart_txq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .sh_done(sh_done),
    .q_empty(fifo_level == '0), .enabled(tx_enabled), .busy(busy),
    .pend_dis(pend_dis), .load_fire(load_fire), .start_ev(start_ev),
    .stop_ev(stop_ev), .done_idle(done_idle)
  );

  uart_txq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .start_ev(start_ev),
    .stop_ev(stop_ev), .enabled(tx_enabled), .push(wr_accept),
    .done_idle(done_idle), .level_nx(fifo_level_nx),
    .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          cmd_reset,
  input logic          cmd_disable,
  input logic          sh_done,
  input logic          sh_load,
  input logic          tx_ready,
  input logic          tx_empty,
  input logic          tx_enabled,
  input logic          wr_accept,
  input logic          busy,
  input logic          pend_dis,
  input logic [LW-1:0] fifo_level
);

  p_off_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enabled |-> !tx_ready);

  p_last_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && wr_valid && !cmd_reset && !sh_load && fifo_level == LW'(DEPTH - 1)
    |=> !tx_ready);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  p_load_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |=> !sh_load);

  p_load_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load && !cmd_reset |=> tx_ready);

  p_write_clears_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !tx_empty);

  p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> !busy && fifo_level == '0 && tx_enabled);

  p_defer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tx_enabled && cmd_disable && !sh_done && !cmd_reset |=> tx_enabled);

  p_pending_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_dis && sh_done && !cmd_reset |=> !tx_enabled && !tx_empty && !tx_ready);

  p_reset_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !tx_enabled && !tx_ready && !tx_empty && !pend_dis);

  p_reset_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |-> !sh_load);

endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .cmd_reset(cmd_reset),
  .cmd_disable(cmd_disable), .sh_done(sh_done), .sh_load(sh_load),
  .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_enabled(tx_enabled),
  .wr_accept(wr_accept), .busy(busy), .pend_dis(pend_dis),
  .fifo_level(fifo_level)
);

// File: tb/uart_txq_tb.sv
`timescale 1ns/1ps
module uart_txq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
  logic       sh_done = 1'b0;
  logic       sh_load, tx_ready, tx_empty, tx_enabled;
  logic [7:0] sh_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_txq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
    .sh_done(sh_done), .sh_load(sh_load), .sh_data(sh_data),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_enabled(tx_enabled)
  );

  // Behavioural reference
  int unsigned q[$];
  bit m_en, m_busy, m_pend, m_rdy, m_emp;
  int cnt = 0;
  int shift_len = 3;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit ld, acc, stopped, started, idle_done, was_busy, was_pend;
    if (!rst_n) begin
      q.delete(); m_en = 0; m_busy = 0; m_pend = 0; m_rdy = 0; m_emp = 0; cnt = 0;
    end else begin
      if (cnt > 0) cnt--;
      if (cmd_reset) begin
        q.delete(); m_en = 0; m_busy = 0; m_pend = 0; m_rdy = 0; m_emp = 0; cnt = 0;
      end else begin
        was_busy = m_busy; was_pend = m_pend;
        stopped = 0; started = 0; idle_done = 0;
        ld  = m_en && !m_busy && q.size() > 0;
        acc = wr_valid && m_rdy;
        if (ld) begin void'(q.pop_front()); m_busy = 1; cnt = shift_len; end
        if (acc) q.push_back(int'(wr_data));
        if (was_busy && sh_done) m_busy = 0;
        if (cmd_disable) begin
          if (m_en) begin
            if (ld || (was_busy && !sh_done)) m_pend = 1;
            else begin m_en = 0; m_pend = 0; stopped = 1; end
          end
        end else if (cmd_enable && !m_en) begin
          m_en = 1; started = 1;
        end
        if (was_busy && sh_done && !stopped) begin
          if (was_pend) begin m_en = 0; m_pend = 0; stopped = 1; end
          else idle_done = 1;
        end
        m_rdy = m_en && q.size() < 8;
        if (stopped || acc) m_emp = 0;
        else if (started) m_emp = (q.size() == 0);
        else if (idle_done && q.size() == 0) m_emp = 1;
      end
    end
  end

  // Serialiser stand-in: done pulse shift_len cycles after a load
  always @(negedge clk) sh_done <= (cnt == 1);

  // Per-cycle comparison, away from the active edge
  always begin
    bit exp_ld;
    @(negedge clk); #3;
    if (rst_n && !finished) begin
      exp_ld = m_en && !m_busy && q.size() > 0 && !cmd_reset;
      check("R5", "sh_load", int'(sh_load), int'(exp_ld));
      if (exp_ld) check("R5", "sh_data", int'(sh_data), int'(q[0]));
      check("R4", "tx_ready", int'(tx_ready), int'(m_rdy));
      check("R6", "tx_empty", int'(tx_empty), int'(m_emp));
      check("R7", "tx_enabled", int'(tx_enabled), int'(m_en));
    end
  end

  task automatic cmd_pulse(bit en, bit dis, bit rst);
    @(negedge clk);
    cmd_enable = en; cmd_disable = dis; cmd_reset = rst;
    @(negedge clk);
    cmd_enable = 0; cmd_disable = 0; cmd_reset = 0;
  endtask

  task automatic write_char(logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek_flags(string tag, bit en, bit rdy, bit emp);
    #3;
    check(tag, "tx_enabled", int'(tx_enabled), int'(en));
    check(tag, "tx_ready", int'(tx_ready), int'(rdy));
    check(tag, "tx_empty", int'(tx_empty), int'(emp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    peek_flags("R1", 0, 0, 0);
    check("R1", "sh_load", int'(sh_load), 0);

    // R3: write while disabled is dropped; R2: enable with empty queue
    write_char(8'h11);
    cmd_pulse(1, 0, 0);
    peek_flags("R2", 1, 1, 1);
    check("R3", "dropped write left queue empty", int'(tx_empty), 1);

    // R5/R6: single character goes out, underrun follows
    write_char(8'hA5);
    idle(10);
    peek_flags("R6", 1, 1, 1);

    // R4/R3: fill the queue while the shifter is slow
    shift_len = 30;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      wr_valid = 1; wr_data = 8'h40 + 8'(i);
      @(negedge clk);
    end
    wr_valid = 0;
    peek_flags("R4", 1, 0, 0);
    idle(320);
    peek_flags("R6", 1, 1, 1);

    // R7: deferred disable
    shift_len = 10;
    write_char(8'hC1);
    write_char(8'hC2);
    cmd_pulse(0, 1, 0);
    #3 check("R7", "held while sending", int'(tx_enabled), 1);
    idle(15);
    peek_flags("R7", 0, 0, 0);
    idle(5);
    cmd_pulse(1, 0, 0);
    peek_flags("R2", 1, 1, 0);
    idle(20);
    peek_flags("R6", 1, 1, 1);

    // R8: disable in underrun
    cmd_pulse(0, 1, 0);
    peek_flags("R8", 0, 0, 0);

    // R9: reset command with a held disable
    cmd_pulse(1, 0, 0);
    write_char(8'hD1); write_char(8'hD2); write_char(8'hD3);
    cmd_pulse(0, 1, 0);
    cmd_pulse(0, 0, 1);
    peek_flags("R9", 0, 0, 0);
    idle(12);
    cmd_pulse(1, 0, 0);
    peek_flags("R9", 1, 1, 1);

    // R10: priority
    cmd_pulse(1, 1, 0);
    peek_flags("R10", 0, 0, 0);
    cmd_pulse(1, 0, 1);
    peek_flags("R10", 0, 0, 0);
    cmd_pulse(1, 1, 1);
    peek_flags("R10", 0, 0, 0);

    // Mixed random traffic, checked every cycle by the model
    cmd_pulse(1, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r;
      @(negedge clk);
      r = int'($urandom_range(0, 999));
      if (i % 200 == 0) shift_len = int'($urandom_range(1, 6));
      wr_valid = (r < 450);
      wr_data = 8'($urandom);
      cmd_disable = (r >= 960 && r < 975);
      cmd_enable = (r >= 975 && r < 995);
      cmd_reset = (r >= 995);
    end
    @(negedge clk);
    wr_valid = 0; cmd_enable = 0; cmd_disable = 0; cmd_reset = 0;
    idle(40);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule